// File: doc/BRIEF.md
# Boost Converter PWM Sequencer with Minimum Off-Time

This block produces the gate command of an average-current-mode boost converter, one switching cycle at a time, from a fast system clock. A programmable cycle timer divides time into switching periods. Each period opens with a forced off window that holds the external ramp discharged and clears the cycle's latches. After the window the ramp is released. The gate switches on at the first clock in which the ramp-crossed-reference flag is seen, and it then stays on until the period ends.

A peak-current comparator runs beside this path. It passes through a synchronizer and a programmable deglitch filter. Once its output is qualified it sets a limit latch, and that latch blanks the gate for the rest of the period. The off window has priority over both latches. The period length and the off-window length are set in clock cycles by register inputs, so the off window also sets the largest duty the block can give. An enable input forces the gate low and restarts the cycle timer.

Top module: `pfc_pwm_core`

## Requirements
- R1: While rst_n is low, gate is 0 and ramp_reset is 1.
- R2: With enable high, a period lasts Pe clocks, where Pe = max(period_cyc, 2). While enable is low the timer is held at the start of a period, so the first period after enable rises is a full one.
- R3: The off window covers the first Oe clocks of every period, where Oe = off_cyc clamped to the range 1..Pe-1. ramp_reset is the off-window flag registered once. gate is never 1 in a cycle where ramp_reset is 1.
- R4: ramp_cross is synchronized by two flops. Outside the off window, the first synchronized high sets the on latch and gate rises on the next clock. gate then stays 1 to the end of the period, even if ramp_cross falls.
- R5: If the synchronized ramp_cross is never high after the off window, gate stays 0 for the whole period (0% duty).
- R6: ilim_raw is synchronized by two flops. It counts as a limit event only on its (glitch_cyc+1)-th consecutive synchronized high sample. A shorter pulse leaves gate unchanged.
- R7: A limit event outside the off window forces gate to 0 on the next clock. gate stays 0 until the next period starts, whatever ramp_cross and ilim_raw do in the meantime.
- R8: The off window clears both latches, whatever the other inputs are doing. A crossing or a limit pulse that has ended before the window closes has no effect on the following on time.
- R9: When enable is low, gate is 0 from the next clock on.
- R10: When the crossing flag is held high and there are no limit events, gate is 1 for exactly Pe-Oe clocks in every window of Pe consecutive clocks. This is the duty ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces gate off and restarts the period |
| period_cyc | input | CNT_W | Switching period in clocks |
| off_cyc | input | CNT_W | Minimum off window in clocks |
| glitch_cyc | input | GL_W | Extra consecutive samples required before a limit event counts |
| ramp_cross | input | 1 | Asynchronous ramp-crossed-reference comparator flag |
| ilim_raw | input | 1 | Asynchronous peak-current comparator flag |
| gate | output | 1 | Registered gate command |
| ramp_reset | output | 1 | Registered ramp discharge command |

## Verification
Two things can fall in the same cycle. A qualified limit event can coincide with the first synchronized crossing, and the off window can open while either latch is set or while a limit pulse is still being qualified. Directed runs line up limit pulses of a chosen length against crossings that are held high, including pulses that start or end inside the off window. Randomized segments then vary the period, the off window, the deglitch length and the edges of both comparators. Every cycle is judged against a reference model that the bench derives from the requirements, in which the limit always wins over the crossing and the off window always wins over both.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;

  // per-cycle latch pair: on latch and current-limit latch
  typedef struct packed {
    logic on;
    logic lim;
  } pwm_latch_t;

  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pfc_cycle_timer.sv
module pfc_cycle_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_cyc,
  input  logic [CNT_W-1:0] off_cyc,
  output logic             off_win
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] off_len;
  logic             at_end;

  always_comb begin
    last_idx = (period_cyc < TWO) ? ONE : (period_cyc - ONE);
    if (off_cyc == '0)          off_len = ONE;
    else if (off_cyc > last_idx) off_len = last_idx;
    else                         off_len = off_cyc;
    at_end  = (cnt_q >= last_idx);
    off_win = (cnt_q < off_len);
  end

  always_comb begin
    if (!enable)     cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // period wraps after last index while the setting is steady
  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $stable(period_cyc) && cnt_q == last_idx) |=> (cnt_q == '0));

  // the first clock of every period lies inside the off window
  assert_window_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> off_win);

  // disabled timer restarts
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

endmodule

// File: rtl/pfc_deglitch.sv
module pfc_deglitch #(
  parameter int unsigned GL_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [GL_W-1:0] hold_cyc,
  output logic            dout
);

  localparam logic [GL_W-1:0] SAT = {GL_W{1'b1}};

  logic [GL_W-1:0] run_q, run_d;

  always_comb begin
    if (!din)             run_d = '0;
    else if (run_q != SAT) run_d = run_q + GL_W'(1);
    else                   run_d = run_q;
    dout = din && (run_q >= hold_cyc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // a fresh rising input never qualifies at once when a hold is asked for
  assert_fresh_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(din) && hold_cyc != '0) |-> !dout);

  // a qualified output with a hold needs the input high one sample earlier
  assert_held_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout && hold_cyc != '0) |-> $past(din));

endmodule

// File: rtl/pfc_pwm_core.sv
module pfc_pwm_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned GL_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_cyc,
  input  logic [CNT_W-1:0] off_cyc,
  input  logic [GL_W-1:0]  glitch_cyc,
  input  logic             ramp_cross,
  input  logic             ilim_raw,
  output logic             gate,
  output logic             ramp_reset
);

  import pfc_pwm_pkg::*;

  logic       off_win;
  logic       cross_s;
  logic       ilim_s;
  logic       lim_evt;
  pwm_latch_t lat_q, lat_d;
  logic       gate_q, gate_d;
  logic       ramp_q, ramp_d;

  pfc_cycle_timer #(.CNT_W(CNT_W)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .period_cyc (period_cyc),
    .off_cyc    (off_cyc),
    .off_win    (off_win)
  );

  pfc_sync #(.STAGES(SYNC_DEPTH)) i_sync_cross (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ramp_cross),
    .q     (cross_s)
  );

  pfc_sync #(.STAGES(SYNC_DEPTH)) i_sync_ilim (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ilim_raw),
    .q     (ilim_s)
  );

  pfc_deglitch #(.GL_W(GL_W)) i_deglitch (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (ilim_s),
    .hold_cyc (glitch_cyc),
    .dout     (lim_evt)
  );

  // latch next state: off window dominates, limit dominates crossing
  always_comb begin
    if (off_win) begin
      lat_d = '0;
    end else begin
      lat_d.lim = lat_q.lim | lim_evt;
      lat_d.on  = lat_q.on  | cross_s;
    end
    gate_d = enable & ~off_win & lat_d.on & ~lat_d.lim;
    ramp_d = off_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      gate_q <= 1'b0;
      ramp_q <= 1'b1;
    end else begin
      lat_q  <= lat_d;
      gate_q <= gate_d;
      ramp_q <= ramp_d;
    end
  end

  assign gate       = gate_q;
  assign ramp_reset = ramp_q;

  // ramp discharge and gate on never overlap
  assert_excl_ramp_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_reset |-> !gate);

  // disabled stage keeps the gate low
  assert_enable_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate);

  // a latched limit blanks the gate for the rest of the period
  assert_limit_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q.lim && !off_win) |=> !gate);

  // a qualified event outside the window turns the gate off next clock
  assert_limit_immediate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_evt && !off_win) |=> !gate);

  // both latches are empty right after an off-window clock
  assert_window_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_win |=> (lat_q == '0));

  // once on, the gate stays on until window or limit
  assert_on_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && enable && !off_win && !lim_evt && !lat_q.lim) |=> gate);

endmodule

// File: tb/test_pfc_pwm_core.sv
module test_pfc_pwm_core;

  localparam int CW = 16;
  localparam int GW = 8;

  logic          clk;
  logic          rst_n;
  logic          enable;
  logic [CW-1:0] period_cyc;
  logic [CW-1:0] off_cyc;
  logic [GW-1:0] glitch_cyc;
  logic          ramp_cross;
  logic          ilim_raw;
  logic          gate;
  logic          ramp_reset;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pfc_pwm_core #(.CNT_W(CW), .GL_W(GW)) i_pfc_pwm_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_cyc(period_cyc),
    .off_cyc(off_cyc), .glitch_cyc(glitch_cyc), .ramp_cross(ramp_cross),
    .ilim_raw(ilim_raw), .gate(gate), .ramp_reset(ramp_reset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // reference model state, built from the requirements
  int m_cnt, m_gcnt;
  bit m_c1, m_c2, m_l1, m_l2, m_on, m_lim, m_gate, m_ramp;

  function automatic int eff_p(int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int eff_o(int o, int pe);
    if (o == 0) return 1;
    if (o > pe - 1) return pe - 1;
    return o;
  endfunction

  function automatic bit limit_qualified(bit s, int run, int hold);
    return s && (run >= hold);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_gcnt = 0;
    m_c1 = 0; m_c2 = 0; m_l1 = 0; m_l2 = 0;
    m_on = 0; m_lim = 0; m_gate = 0; m_ramp = 1;
  endtask

  task automatic model_adv();
    int  pe, oe;
    bit  win, evt, on_n, lim_n;
    pe  = eff_p(int'(period_cyc));
    oe  = eff_o(int'(off_cyc), pe);
    win = (m_cnt < oe);
    evt = limit_qualified(m_l2, m_gcnt, int'(glitch_cyc));
    on_n  = win ? 1'b0 : (m_on  | m_c2);
    lim_n = win ? 1'b0 : (m_lim | evt);
    m_gate = enable && !win && on_n && !lim_n;
    m_ramp = win;
    m_on = on_n; m_lim = lim_n;
    if (!m_l2) m_gcnt = 0;
    else if (m_gcnt < 255) m_gcnt = m_gcnt + 1;
    m_c2 = m_c1; m_c1 = ramp_cross;
    m_l2 = m_l1; m_l1 = ilim_raw;
    if (!enable || m_cnt >= pe - 1) m_cnt = 0;
    else m_cnt = m_cnt + 1;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (gate !== m_gate || ramp_reset !== m_ramp) begin
      errors++;
      $display("FAIL %s: gate/ramp_reset actual %b/%b expected %b/%b at %0t",
               tag, gate, ramp_reset, m_gate, m_ramp, $time);
    end
  endtask

  task automatic step(input string tag);
    model_adv();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // count gate highs over n cycles and compare with a formula value
  task automatic count_high(input int n, input int exp, input string tag);
    int hits;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step(tag);
      if (gate) hits++;
    end
    checks++;
    if (hits != exp) begin
      errors++;
      $display("FAIL %s: gate-high count actual %0d expected %0d", tag, hits, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles actual 200000 expected fewer");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; enable = 1'b0; period_cyc = 16'd20; off_cyc = 16'd2;
    glitch_cyc = 8'd0; ramp_cross = 1'b0; ilim_raw = 1'b0;
    model_reset();
    // R1: outputs during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare("R1 reset");
    end
    rst_n = 1'b1;

    // R10: crossing always high gives Pe-Oe highs per period
    enable = 1'b1; ramp_cross = 1'b1;
    run(45, "R10 settle");
    count_high(20, 18, "R10 duty ceiling P20 O2");
    off_cyc = 16'd5;
    run(25, "R3 window change");
    count_high(20, 15, "R3 off window O5");

    // R5: no crossing gives zero duty
    ramp_cross = 1'b0;
    run(25, "R5 settle");
    count_high(40, 0, "R5 no crossing");

    // R4: short crossing pulse still latches gate until period end
    run(7, "R4 align");
    ramp_cross = 1'b1; step("R4 pulse");
    ramp_cross = 1'b0;
    run(40, "R4 latch hold");

    // R6 / R7: short limit pulse ignored, long one blanks
    glitch_cyc = 8'd3; ramp_cross = 1'b1;
    run(30, "R6 settle");
    ilim_raw = 1'b1; run(3, "R6 short pulse");
    ilim_raw = 1'b0; run(20, "R6 short pulse ignored");
    ilim_raw = 1'b1; run(5, "R7 long pulse");
    ilim_raw = 1'b0; run(25, "R7 blank rest of period");

    // R8: limit pulse inside a long off window
    period_cyc = 16'd30; off_cyc = 16'd12; glitch_cyc = 8'd0;
    run(31, "R8 settle");
    for (int k = 0; k < 30; k++) begin
      ilim_raw = (k >= 2 && k < 6);
      step("R8 window priority");
    end
    ilim_raw = 1'b0;
    run(30, "R8 next period");

    // R9: enable drop and restart
    enable = 1'b0; run(10, "R9 enable low");
    enable = 1'b1; run(35, "R9 restart");

    // R2 / R3: clamps of period and off window
    period_cyc = 16'd0; off_cyc = 16'd0;
    run(12, "R2 period clamp");
    period_cyc = 16'd6; off_cyc = 16'd9;
    run(13, "R3 off clamp settle");
    count_high(12, 2, "R3 off clamp to Pe-1");
    period_cyc = 16'd1;
    run(10, "R2 period one");

    // randomized segments
    for (int seg = 0; seg < 12; seg++) begin
      int p;
      p = 2 + int'($urandom % 30);
      period_cyc = CW'(p);
      off_cyc    = CW'($urandom % (p + 3));
      glitch_cyc = GW'($urandom % 5);
      for (int c = 0; c < 300; c++) begin
        if ($urandom % 8 == 0) ramp_cross = ~ramp_cross;
        if ($urandom % 6 == 0) ilim_raw   = ~ilim_raw;
        if ($urandom % 97 == 0) enable    = ~enable;
        step("R4 random mix");
      end
      enable = 1'b1;
    end

    finish_run();
  end

endmodule